// File: doc/BRIEF.md
# Dual-Channel I/Q Output Formatter with Serial and Parallel Ports

This block takes one result pair (I and Q) from each of two channels and turns every sample into an output word. The word can be a fixed-point value of 8, 16, 24 or 32 bits, or a 12-bit floating-point code. Each accepted set of four words goes out in two ways. It is shifted out on a framed serial port that has its own bit clock, frame sync and ready pulse. It is also latched into a holding bank that a 16-bit parallel port reads through a 3-bit select.

Inputs are 32-bit two's complement samples. A new set is taken only while the serial port is idle. The format code and the multiplex mode are sampled with the set and stay fixed for the whole transfer. The polarity inputs act on the outputs at once. In multiplex mode both channels leave on serial line A, and line B stays low.

Top module: `dual_iq_out_fmt`

## Requirements
- R1: Format code 3 gives a 32-bit word equal to the input. Format code 0 gives the top 8 input bits, truncated and sign-extended. Codes 5 to 7 behave like code 3.
- R2: Format code 1 (16-bit) and format code 2 (24-bit) round half up on the discarded low bits. A positive result that would overflow saturates to the largest positive value of that width.
- R3: Format code 4 gives a 12-bit code {exponent[3:0], mantissa[7:0]}, zero-extended to 32 bits. The exponent is the number of left shifts that normalise the input, capped at 15. The mantissa is the top 8 bits of the shifted input.
- R4: A frame is the I word followed by the Q word, each sent MSB first. Each bit lasts two clock cycles: the raw bit clock is low in the first cycle and high in the second. The raw frame sync is high for the first bit of every frame.
- R5: The outputs sck, sfs and rdy are the raw levels XOR pol_sck, pol_sfs and pol_rdy respectively. When idle, all three raw levels are low.
- R6: The raw ready level goes high in the cycle after a set is accepted and lasts exactly 2 clock cycles.
- R7: In multiplex mode (mux_en=1 at acceptance), line A carries the channel-A frame and then the channel-B frame, and line B stays 0.
- R8: With mux_en=0, line A carries the channel-A frame and line B carries the channel-B frame, in the same cycles.
- R9: The parallel select maps {psel[2:1], psel[0]} to {word index, half}. Word index 0 is A-I, 1 is A-Q, 2 is B-I and 3 is B-Q. Half 0 is bits 31:16 and half 1 is bits 15:0 of the held 32-bit word. pout is 0 while pout_en is low.
- R10: An input set offered while a transfer is in progress is ignored. This includes an offer on the final clock edge of the transfer. The held words, the serial data and the ready output stay unchanged.
- R11: After reset the holding bank is zero and the serial port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Offers a new four-sample set |
| a_i | input | 32 | Channel A in-phase sample |
| a_q | input | 32 | Channel A quadrature sample |
| b_i | input | 32 | Channel B in-phase sample |
| b_q | input | 32 | Channel B quadrature sample |
| fmt_sel | input | 3 | Output word format code |
| mux_en | input | 1 | Both channels on serial line A |
| pol_sck | input | 1 | Bit clock inversion |
| pol_sfs | input | 1 | Frame sync inversion |
| pol_rdy | input | 1 | Ready inversion |
| psel | input | 3 | Parallel word and half select |
| pout_en | input | 1 | Parallel output enable |
| sck | output | 1 | Serial bit clock |
| sfs | output | 1 | Serial frame sync |
| rdy | output | 1 | New-set ready pulse |
| sout_a | output | 1 | Serial data line A |
| sout_b | output | 1 | Serial data line B |
| pout | output | 16 | Parallel output word |

## Verification
Two events can meet in one cycle: a new input offer, and the last bit-clock phase of a transfer that is still running. The bench raises in_valid on exactly that edge, and also in the middle of a frame, with different sample values on the inputs. The offer is judged rejected if ready stays at its idle level in the following cycle. The serial words and every parallel readback must also still match the original set. The sweep covers all five formats, both multiplex modes and all eight polarity combinations, using rounding-boundary, saturation and sign-corner inputs.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
    localparam int DW      = 32;
    localparam int NWORD   = 4;
    localparam int RDY_LEN = 2;
    localparam int CW      = $clog2(4 * DW + 1);

    localparam logic [2:0] FMT_8   = 3'd0;
    localparam logic [2:0] FMT_16  = 3'd1;
    localparam logic [2:0] FMT_24  = 3'd2;
    localparam logic [2:0] FMT_32  = 3'd3;
    localparam logic [2:0] FMT_FLT = 3'd4;

    function automatic int fmt_bits(input logic [2:0] f);
        case (f)
            FMT_8:   return 8;
            FMT_16:  return 16;
            FMT_24:  return 24;
            FMT_FLT: return 12;
            default: return DW;
        endcase
    endfunction
endpackage

// File: rtl/ofmt_word.sv
module ofmt_word
    import ofmt_pkg::*;
(
    input  logic [2:0]           fmt,
    input  logic signed [DW-1:0] x,
    output logic [DW-1:0]        y
);
    localparam int D16 = DW - 16;
    localparam int D24 = DW - 24;

    logic signed [DW:0] s16, s24;
    logic [16:0]        r16;
    logic [24:0]        r24;
    logic [3:0]         f_exp;
    logic [DW-1:0]      f_shift;
    logic               f_run;

    always_comb begin
        s16 = {x[DW-1], x} + ((DW + 1)'(1) << (D16 - 1));
        s24 = {x[DW-1], x} + ((DW + 1)'(1) << (D24 - 1));
        r16 = s16[DW:D16];
        r24 = s24[DW:D24];

        f_exp = 4'd0;
        f_run = 1'b1;
        for (int i = DW - 2; i >= DW - 16; i--) begin
            if (f_run && (x[i] == x[DW-1])) f_exp = f_exp + 4'd1;
            else f_run = 1'b0;
        end
        f_shift = x << f_exp;

        case (fmt)
            FMT_8:  y = {{(DW-8){x[DW-1]}}, x[DW-1:DW-8]};
            FMT_16: y = (r16[16] != r16[15]) ? DW'(16'h7FFF)
                                             : {{(DW-16){r16[15]}}, r16[15:0]};
            FMT_24: y = (r24[24] != r24[23]) ? DW'(24'h7FFFFF)
                                             : {{(DW-24){r24[23]}}, r24[23:0]};
            FMT_FLT: y = DW'({f_exp, f_shift[DW-1:DW-8]});
            default: y = x;
        endcase
    end
endmodule

// File: rtl/ofmt_serial.sv
module ofmt_serial
    import ofmt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 fmt,
    input  logic                       mux,
    input  logic [NWORD-1:0][DW-1:0]   words,
    output logic                       busy,
    output logic                       sck_raw,
    output logic                       sfs_raw,
    output logic                       sa,
    output logic                       sb
);
    typedef struct packed {
        logic            busy;
        logic            ph;
        logic            mux;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   fl;
        logic [2*DW-1:0] sra;
        logic [2*DW-1:0] srb;
    } ser_t;

    ser_t st_q, st_d;

    function automatic logic [2*DW-1:0] pack_pair(input logic [DW-1:0] wi,
                                                  input logic [DW-1:0] wq,
                                                  input int w);
        logic [2*DW-1:0] hi, lo;
        hi = {wi << (DW - w), {DW{1'b0}}};
        lo = {{DW{1'b0}}, wq << (DW - w)} << (DW - w);
        return hi | lo;
    endfunction

    logic [CW-1:0] last_bit;

    always_comb begin
        st_d     = st_q;
        last_bit = (st_q.mux ? (st_q.fl << 1) : st_q.fl) - CW'(1);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.ph   = 1'b0;
                st_d.cnt  = '0;
                st_d.mux  = mux;
                st_d.fl   = CW'(2 * fmt_bits(fmt));
                st_d.sra  = pack_pair(words[0], words[1], fmt_bits(fmt));
                st_d.srb  = pack_pair(words[2], words[3], fmt_bits(fmt));
            end
        end else if (!st_q.ph) begin
            st_d.ph = 1'b1;
        end else begin
            st_d.ph  = 1'b0;
            st_d.cnt = st_q.cnt + CW'(1);
            if (!st_q.mux || (st_q.cnt < st_q.fl))  st_d.sra = st_q.sra << 1;
            if (!st_q.mux || (st_q.cnt >= st_q.fl)) st_d.srb = st_q.srb << 1;
            if (st_q.cnt == last_bit) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sck_raw = st_q.busy & st_q.ph;
    assign sfs_raw = st_q.busy & ((st_q.cnt == '0) | (st_q.mux & (st_q.cnt == st_q.fl)));
    assign sa      = st_q.busy & ((st_q.mux && (st_q.cnt >= st_q.fl)) ? st_q.srb[2*DW-1]
                                                                      : st_q.sra[2*DW-1]);
    assign sb      = st_q.busy & ~st_q.mux & st_q.srb[2*DW-1];

    AST_SCK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        sck_raw |=> !sck_raw); // R4
endmodule

// File: rtl/dual_iq_out_fmt.sv
module dual_iq_out_fmt
    import ofmt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   a_i,
    input  logic [31:0]   a_q,
    input  logic [31:0]   b_i,
    input  logic [31:0]   b_q,
    input  logic [2:0]    fmt_sel,
    input  logic          mux_en,
    input  logic          pol_sck,
    input  logic          pol_sfs,
    input  logic          pol_rdy,
    input  logic [2:0]    psel,
    input  logic          pout_en,
    output logic          sck,
    output logic          sfs,
    output logic          rdy,
    output logic          sout_a,
    output logic          sout_b,
    output logic [15:0]   pout
);
    typedef struct packed {
        logic [NWORD-1:0][DW-1:0] hold;
        logic [1:0]               rdy_cnt;
    } top_t;

    top_t st_q, st_d;

    logic [NWORD-1:0][DW-1:0] raw, fw;
    logic                     start, ser_busy, sck_raw, sfs_raw, sa, sb, rdy_raw;
    logic [DW-1:0]            sel_word;

    assign raw = {b_q, b_i, a_q, a_i};

    for (genvar g = 0; g < NWORD; g++) begin : g_fmt
        ofmt_word u_word (
            .fmt (fmt_sel),
            .x   (raw[g]),
            .y   (fw[g])
        );
    end

    assign start = in_valid & ~ser_busy;

    ofmt_serial u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fmt     (fmt_sel),
        .mux     (mux_en),
        .words   (fw),
        .busy    (ser_busy),
        .sck_raw (sck_raw),
        .sfs_raw (sfs_raw),
        .sa      (sa),
        .sb      (sb)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.hold    = fw;
            st_d.rdy_cnt = 2'(RDY_LEN);
        end else if (st_q.rdy_cnt != '0) begin
            st_d.rdy_cnt = st_q.rdy_cnt - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy_raw  = (st_q.rdy_cnt != '0);
    assign sel_word = st_q.hold[psel[2:1]];
    assign pout     = pout_en ? (psel[0] ? sel_word[15:0] : sel_word[31:16]) : 16'h0000;
    assign sck      = sck_raw ^ pol_sck;
    assign sfs      = sfs_raw ^ pol_sfs;
    assign rdy      = rdy_raw ^ pol_rdy;
    assign sout_a   = sa;
    assign sout_b   = sb;

    AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_raw) |=> rdy_raw); // R6
    AST_RDY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_raw && $past(rdy_raw)) |=> !rdy_raw); // R6
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_busy && in_valid) |=> $stable(st_q.hold)); // R10
    AST_LINE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mux_en) |=> !sout_b); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !a_i[DW-1]) |-> !fw[0][DW-1]); // R2
endmodule

// File: tb/dual_iq_out_fmt_bench.sv
module dual_iq_out_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
    logic [2:0]  fmt_sel = '0;
    logic        mux_en = 1'b0, pol_sck = 1'b0, pol_sfs = 1'b0, pol_rdy = 1'b0;
    logic [2:0]  psel = '0;
    logic        pout_en = 1'b0;
    logic        sck, sfs, rdy, sout_a, sout_b;
    logic [15:0] pout;

    int total_checks = 0;
    int bad_checks = 0;
    logic [31:0] va [4];
    logic [31:0] corner [16];

    always #2 clk = ~clk;

    dual_iq_out_fmt u_dual_iq_out_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
        .fmt_sel(fmt_sel), .mux_en(mux_en),
        .pol_sck(pol_sck), .pol_sfs(pol_sfs), .pol_rdy(pol_rdy),
        .psel(psel), .pout_en(pout_en),
        .sck(sck), .sfs(sfs), .rdy(rdy), .sout_a(sout_a), .sout_b(sout_b),
        .pout(pout)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ref_w(input int f);
        case (f)
            0: return 8;
            1: return 16;
            2: return 24;
            4: return 12;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] ref_word(input int f, input logic [31:0] x);
        longint v, r;
        logic [31:0] s;
        int e;
        v = longint'($signed(x));
        case (f)
            0: return 32'(v >>> 24);
            1: begin r = (v + 32768) >>> 16; if (r > 32767) r = 32767; return 32'(r); end
            2: begin r = (v + 128) >>> 8; if (r > 8388607) r = 8388607; return 32'(r); end
            4: begin
                s = x; e = 0;
                while (e < 15 && s[31] == s[30]) begin s = s << 1; e++; end
                return {20'd0, 4'(e), s[31:24]};
            end
            default: return x;
        endcase
    endfunction

    function automatic string fmt_tag(input int f);
        if (f == 4) return "R3";
        if (f == 1 || f == 2) return "R2";
        return "R1";
    endfunction

    task automatic run_frame(input int f, input bit mx, input bit intrude);
        int w, fl, total;
        logic [31:0] expw [4];
        logic [127:0] ga, gb;
        logic [31:0] mask, got, pe;
        bit tim_bad;
        w = ref_w(f); fl = 2 * w; total = mx ? 2 * fl : fl;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        for (int k = 0; k < 4; k++) expw[k] = ref_word(f, va[k]);
        ga = '0; gb = '0; tim_bad = 1'b0;
        fmt_sel = 3'(f); mux_en = mx;
        a_i = va[0]; a_q = va[1]; b_i = va[2]; b_q = va[3];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int n = 0; n < 2 * total; n++) begin
            if (n < 3) check(rdy === ((n < 2) ^ pol_rdy), "R6 rdy pulse", {31'd0, rdy},
                             {31'd0, (n < 2) ^ pol_rdy});
            if (sck !== (n[0] ^ pol_sck)) tim_bad = 1'b1;
            if (!n[0]) begin
                if (sfs !== (((n / 2 == 0) || (mx && (n / 2 == fl))) ^ pol_sfs)) tim_bad = 1'b1;
                ga = {ga[126:0], sout_a};
                gb = {gb[126:0], sout_b};
            end
            if (intrude && n == 4) begin
                a_i = ~va[0]; a_q = ~va[1]; b_i = ~va[2]; b_q = ~va[3];
                in_valid = 1'b1;
            end
            if (intrude && n == 5) in_valid = 1'b0;
            if (intrude && n == 2 * total - 1) in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        a_i = va[0]; a_q = va[1]; b_i = va[2]; b_q = va[3];
        check(sck === pol_sck && sfs === pol_sfs && rdy === pol_rdy,
              "R10 idle after frame, late offer ignored", {29'd0, sck, sfs, rdy},
              {29'd0, pol_sck, pol_sfs, pol_rdy});
        check(!tim_bad, "R4 R5 bit clock and frame sync timing", {31'd0, tim_bad}, 32'd0);
        got = 32'((ga >> (total - w))) & mask;
        check(got == (expw[0] & mask), fmt_tag(f), got, expw[0] & mask);
        got = 32'((ga >> (total - 2 * w))) & mask;
        check(got == (expw[1] & mask), "R4 Q follows I", got, expw[1] & mask);
        if (mx) begin
            got = 32'((ga >> (total - 3 * w))) & mask;
            check(got == (expw[2] & mask), "R7 B-I on line A", got, expw[2] & mask);
            got = 32'(ga) & mask;
            check(got == (expw[3] & mask), "R7 B-Q on line A", got, expw[3] & mask);
            check(gb == '0, "R7 line B low", 32'(gb), 32'd0);
        end else begin
            got = 32'((gb >> (total - w))) & mask;
            check(got == (expw[2] & mask), "R8 B-I on line B", got, expw[2] & mask);
            got = 32'(gb) & mask;
            check(got == (expw[3] & mask), "R8 B-Q on line B", got, expw[3] & mask);
        end
        pout_en = 1'b1;
        for (int p = 0; p < 8; p++) begin
            psel = 3'(p);
            #1;
            pe = expw[p >> 1];
            check(pout === (p[0] ? pe[15:0] : pe[31:16]), "R9 parallel select",
                  {16'd0, pout}, {16'd0, p[0] ? pe[15:0] : pe[31:16]});
        end
        pout_en = 1'b0;
        #1;
        check(pout === 16'h0, "R9 enable low", {16'd0, pout}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_checks++;
        total_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin
        corner[0]  = 32'h0000_0000; corner[1]  = 32'hFFFF_FFFF;
        corner[2]  = 32'h7FFF_FFFF; corner[3]  = 32'h8000_0000;
        corner[4]  = 32'h0000_8000; corner[5]  = 32'h0000_7FFF;
        corner[6]  = 32'hFFFF_8000; corner[7]  = 32'h7FFF_8000;
        corner[8]  = 32'h0000_0080; corner[9]  = 32'h1234_5678;
        corner[10] = 32'hEDCB_A987; corner[11] = 32'h0001_0000;
        corner[12] = 32'h0000_00FF; corner[13] = 32'h7FFF_FF80;
        corner[14] = 32'hFFFF_FF7F; corner[15] = 32'h0000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pout_en = 1'b1;
        #1;
        check(sck === 1'b0 && sfs === 1'b0 && rdy === 1'b0 && sout_a === 1'b0
              && sout_b === 1'b0, "R11 serial idle after reset",
              {27'd0, sck, sfs, rdy, sout_a, sout_b}, 32'd0);
        check(pout === 16'h0, "R11 hold bank zero", {16'd0, pout}, 32'd0);
        pout_en = 1'b0;
        @(negedge clk);
        for (int f = 0; f < 5; f++) begin
            for (int mx = 0; mx < 2; mx++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int k = 0; k < 4; k++) va[k] = corner[(j + k * 5 + f) % 16];
                    pol_sck = j[0]; pol_sfs = j[1]; pol_rdy = j[2];
                    @(negedge clk);
                    run_frame(f, mx[0], j[1:0] == 2'b11);
                end
            end
        end
        for (int k = 0; k < 4; k++) va[k] = corner[k + 9];
        run_frame(6, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule